// File: doc/BRIEF.md
# Cache-Line Request Merger

This block sits between a group of load/store units and a single-ported cache-line store that can do one read or one write per clock. Each unit owns two request slots. Slot `2*u` carries the part of unit `u`'s access that lies in its first line, and slot `2*u+1` carries the part that spills into the next line. A slot request names a line address, a 16-bit byte mask and whether it is a load or a store. The block keeps each accepted request in a slot register until it is served.

Every cycle the merger takes the lowest-numbered pending slot as the leader. It then serves, in one access, every pending slot that has the same line address and the same operation as the leader. The byte masks of the served slots are ORed into one merged mask. Per-slot grant pulses tell each unit which of its slots were served. Slots that were not chosen keep their request and compete again in later cycles. Data steering and ordering of overlapping stores are handled elsewhere.

Top module: `lrm_top`

## Requirements
- R1: While reset is held and after its release, before any request arrives, no slot is pending, all grants are low, `mrg_valid` is low and `mrg_line` and `mrg_mask` are zero.
- R2: A request with `in_valid[i]` high at a rising edge, when slot `i` is not pending, makes `slot_pending[i]` high after that edge.
- R3: While slot `i` is pending, its request inputs are ignored. The line, mask and operation served at its grant are those captured when it became pending.
- R4: The leader is the lowest-numbered pending slot. One edge after the arbitration state, `mrg_line` and `mrg_store` equal the leader's line and operation (`in_store`=1 means store).
- R5: Every pending slot with the leader's line address and operation is granted in the same cycle, and `mrg_mask` is the bitwise OR of their byte masks.
- R6: A pending slot whose line address or operation differs from the leader's is not granted and stays pending.
- R7: A grant is a single-cycle pulse. The slot's pending flag clears at the same edge that raises its grant.
- R8: When no slot is pending at an edge, after that edge all grants are low, `mrg_valid` is low and `mrg_line` and `mrg_mask` are zero.
- R9: `mrg_valid` is high exactly when at least one grant bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | NSLOT | Request present for each slot |
| in_store | input | NSLOT | Operation per slot: 1 store, 0 load |
| in_line | input | NSLOT*LINE_W | Line address per slot, slot i at bits [i*LINE_W +: LINE_W] |
| in_mask | input | NSLOT*MASK_W | Byte mask per slot, slot i at bits [i*MASK_W +: MASK_W] |
| slot_pending | output | NSLOT | Slot holds an unserved request |
| grant | output | NSLOT | One-cycle pulse per served slot |
| mrg_valid | output | 1 | A merged access is issued this cycle |
| mrg_store | output | 1 | Operation of the merged access |
| mrg_line | output | LINE_W | Line address of the merged access |
| mrg_mask | output | MASK_W | OR of the byte masks of the served slots |

## Verification
The hardest case to reach is a crowded slot set. In that state, pending slots that share the leader's line but have the other operation sit next to slots on other lines. New requests also keep arriving for slots that are still waiting. Random stimulus reaches this state by drawing line addresses from a pool of only four values and driving every slot's inputs on nearly every cycle, so that ignored writes to pending slots happen all the time. Directed sequences add a full sixteen-slot merge, a split between loads and stores on one line, and an explicit overwrite attempt on a blocked slot.

// File: rtl/lrm_pkg.sv
package lrm_pkg;
  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_STORE = 1'b1
  } op_e;

  localparam int unsigned LRM_MASK_W = 16;
endpackage

// File: rtl/lrm_slot_bank.sv
module lrm_slot_bank #(
  parameter int unsigned NSLOT  = 16,
  parameter int unsigned LINE_W = 28,
  parameter int unsigned MASK_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSLOT-1:0]          in_valid,
  input  logic [NSLOT-1:0]          in_store,
  input  logic [NSLOT*LINE_W-1:0]   in_line,
  input  logic [NSLOT*MASK_W-1:0]   in_mask,
  input  logic [NSLOT-1:0]          clr,
  output logic [NSLOT-1:0]          pend,
  output logic [NSLOT-1:0]          store,
  output logic [NSLOT*LINE_W-1:0]   line,
  output logic [NSLOT*MASK_W-1:0]   mask
);
  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic              load_en;
    logic              pend_d;
    logic              pend_q;
    logic              store_q;
    logic [LINE_W-1:0] line_q;
    logic [MASK_W-1:0] mask_q;

    always_comb begin
      load_en = in_valid[i] & ~pend_q;
      pend_d  = (pend_q & ~clr[i]) | load_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
      end else begin
        pend_q <= pend_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        store_q <= 1'b0;
        line_q  <= '0;
        mask_q  <= '0;
      end else if (load_en) begin
        store_q <= in_store[i];
        line_q  <= in_line[i*LINE_W +: LINE_W];
        mask_q  <= in_mask[i*MASK_W +: MASK_W];
      end
    end

    assign pend[i]                    = pend_q;
    assign store[i]                   = store_q;
    assign line[i*LINE_W +: LINE_W]   = line_q;
    assign mask[i*MASK_W +: MASK_W]   = mask_q;
  end
endmodule

// File: rtl/lrm_leader_pick.sv
module lrm_leader_pick
  import lrm_pkg::*;
#(
  parameter int unsigned NSLOT  = 16,
  parameter int unsigned LINE_W = 28,
  localparam int unsigned IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic [NSLOT-1:0]        pend,
  input  logic [NSLOT-1:0]        store,
  input  logic [NSLOT*LINE_W-1:0] line,
  output logic                    any,
  output logic [IDX_W-1:0]        lead_idx,
  output logic [LINE_W-1:0]       lead_line,
  output op_e                     lead_op
);
  always_comb begin
    any      = 1'b0;
    lead_idx = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (pend[i]) begin
        any      = 1'b1;
        lead_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    lead_line = line[lead_idx*LINE_W +: LINE_W];
    lead_op   = store[lead_idx] ? OP_STORE : OP_LOAD;
  end
endmodule

// File: rtl/lrm_match_merge.sv
module lrm_match_merge
  import lrm_pkg::*;
#(
  parameter int unsigned NSLOT  = 16,
  parameter int unsigned LINE_W = 28,
  parameter int unsigned MASK_W = 16
) (
  input  logic [NSLOT-1:0]        pend,
  input  logic [NSLOT-1:0]        store,
  input  logic [NSLOT*LINE_W-1:0] line,
  input  logic [NSLOT*MASK_W-1:0] mask,
  input  logic                    any,
  input  logic [LINE_W-1:0]       lead_line,
  input  op_e                     lead_op,
  output logic [NSLOT-1:0]        gnt,
  output logic [MASK_W-1:0]       mask_or
);
  logic [NSLOT-1:0] same_line;
  logic [NSLOT-1:0] same_op;

  for (genvar i = 0; i < NSLOT; i++) begin : g_cmp
    assign same_line[i] = (line[i*LINE_W +: LINE_W] == lead_line);
    assign same_op[i]   = (store[i] == (lead_op == OP_STORE));
    assign gnt[i]       = any & pend[i] & same_line[i] & same_op[i];
  end

  always_comb begin
    mask_or = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (gnt[i]) begin
        mask_or = mask_or | mask[i*MASK_W +: MASK_W];
      end
    end
  end
endmodule

// File: rtl/lrm_top.sv
module lrm_top
  import lrm_pkg::*;
#(
  parameter int unsigned NUM_UNITS      = 8,
  parameter int unsigned SLOTS_PER_UNIT = 2,
  parameter int unsigned LINE_W         = 28,
  parameter int unsigned MASK_W         = LRM_MASK_W,
  localparam int unsigned NSLOT         = NUM_UNITS * SLOTS_PER_UNIT,
  localparam int unsigned IDX_W         = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSLOT-1:0]          in_valid,
  input  logic [NSLOT-1:0]          in_store,
  input  logic [NSLOT*LINE_W-1:0]   in_line,
  input  logic [NSLOT*MASK_W-1:0]   in_mask,
  output logic [NSLOT-1:0]          slot_pending,
  output logic [NSLOT-1:0]          grant,
  output logic                      mrg_valid,
  output logic                      mrg_store,
  output logic [LINE_W-1:0]         mrg_line,
  output logic [MASK_W-1:0]         mrg_mask
);
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  logic rst_int_n;
  assign rst_int_n = rst_s2_q;

  logic [NSLOT-1:0]        s_pend, s_store, gnt_d;
  logic [NSLOT*LINE_W-1:0] s_line;
  logic [NSLOT*MASK_W-1:0] s_mask;
  logic                    any;
  logic [IDX_W-1:0]        lead_idx;
  logic [LINE_W-1:0]       lead_line;
  op_e                     lead_op;
  logic [MASK_W-1:0]       mask_or;

  lrm_slot_bank #(.NSLOT(NSLOT), .LINE_W(LINE_W), .MASK_W(MASK_W)) u_bank (
    .clk(clk), .rst_n(rst_int_n),
    .in_valid(in_valid), .in_store(in_store), .in_line(in_line), .in_mask(in_mask),
    .clr(gnt_d),
    .pend(s_pend), .store(s_store), .line(s_line), .mask(s_mask)
  );

  lrm_leader_pick #(.NSLOT(NSLOT), .LINE_W(LINE_W)) u_pick (
    .pend(s_pend), .store(s_store), .line(s_line),
    .any(any), .lead_idx(lead_idx), .lead_line(lead_line), .lead_op(lead_op)
  );

  lrm_match_merge #(.NSLOT(NSLOT), .LINE_W(LINE_W), .MASK_W(MASK_W)) u_merge (
    .pend(s_pend), .store(s_store), .line(s_line), .mask(s_mask),
    .any(any), .lead_line(lead_line), .lead_op(lead_op),
    .gnt(gnt_d), .mask_or(mask_or)
  );

  logic [NSLOT-1:0]  grant_d;
  logic              valid_d, store_d;
  logic [LINE_W-1:0] line_d;
  logic [MASK_W-1:0] mask_d;

  always_comb begin
    grant_d = gnt_d;
    valid_d = any;
    store_d = any & (lead_op == OP_STORE);
    line_d  = any ? lead_line : '0;
    mask_d  = mask_or;
  end

  logic [NSLOT-1:0]  grant_q;
  logic              valid_q, store_q;
  logic [LINE_W-1:0] line_q;
  logic [MASK_W-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      grant_q <= '0;
      valid_q <= 1'b0;
      store_q <= 1'b0;
      line_q  <= '0;
      mask_q  <= '0;
    end else begin
      grant_q <= grant_d;
      valid_q <= valid_d;
      store_q <= store_d;
      line_q  <= line_d;
      mask_q  <= mask_d;
    end
  end

  assign slot_pending = s_pend;
  assign grant        = grant_q;
  assign mrg_valid    = valid_q;
  assign mrg_store    = store_q;
  assign mrg_line     = line_q;
  assign mrg_mask     = mask_q;
endmodule

// File: rtl/lrm_checker.sv
module lrm_checker #(
  parameter int unsigned NSLOT  = 16,
  parameter int unsigned LINE_W = 28,
  parameter int unsigned MASK_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSLOT-1:0]  in_valid,
  input logic [NSLOT-1:0]  slot_pending,
  input logic [NSLOT-1:0]  grant,
  input logic              mrg_valid,
  input logic [LINE_W-1:0] mrg_line,
  input logic [MASK_W-1:0] mrg_mask
);
  logic [NSLOT-1:0] pend_low;
  logic [NSLOT-1:0] take;
  assign pend_low = slot_pending & (~slot_pending + {{(NSLOT-1){1'b0}}, 1'b1});
  assign take     = in_valid & ~slot_pending;

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|take) |=> ((slot_pending & $past(take)) == $past(take)));

  assert_leader_served_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_pending) |=> (|(grant & $past(pend_low))));

  assert_only_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((grant & ~$past(slot_pending)) == '0));

  assert_clear_on_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & slot_pending) == '0);

  assert_grant_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |=> ((grant & $past(grant)) == '0));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mrg_valid |-> (mrg_mask == '0 && mrg_line == '0 && grant == '0));

  assert_valid_iff_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mrg_valid == (|grant));
endmodule

bind lrm_top lrm_checker #(.NSLOT(NSLOT), .LINE_W(LINE_W), .MASK_W(MASK_W)) u_lrm_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .slot_pending(slot_pending),
  .grant(grant), .mrg_valid(mrg_valid), .mrg_line(mrg_line), .mrg_mask(mrg_mask)
);

// File: tb/tb_lrm_top.sv
`timescale 1ns/1ps
module tb_lrm_top;
  localparam int NU = 8, SPU = 2, NS = NU*SPU, LW = 28, MW = 16;
  localparam real CLK_P = 20.0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NS-1:0] in_valid, in_store;
  logic [NS*LW-1:0] in_line;
  logic [NS*MW-1:0] in_mask;
  logic [NS-1:0] slot_pending, grant;
  logic mrg_valid, mrg_store;
  logic [LW-1:0] mrg_line;
  logic [MW-1:0] mrg_mask;

  lrm_top #(.NUM_UNITS(NU), .SLOTS_PER_UNIT(SPU), .LINE_W(LW), .MASK_W(MW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_store(in_store),
    .in_line(in_line), .in_mask(in_mask), .slot_pending(slot_pending),
    .grant(grant), .mrg_valid(mrg_valid), .mrg_store(mrg_store),
    .mrg_line(mrg_line), .mrg_mask(mrg_mask));

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit [NS-1:0] m_pend, m_st;
  bit [LW-1:0] m_ln [NS];
  bit [MW-1:0] m_mk [NS];
  bit [NS-1:0] d_v, d_st;
  bit [LW-1:0] d_ln [NS];
  bit [MW-1:0] d_mk [NS];
  bit [NS-1:0] e_gnt;
  bit e_val, e_st;
  bit [LW-1:0] e_ln;
  bit [MW-1:0] e_mk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void predict();
    int lead = -1;
    e_gnt = '0; e_mk = '0; e_ln = '0; e_st = 1'b0; e_val = 1'b0;
    for (int i = 0; i < NS; i++) if (m_pend[i] && lead < 0) lead = i;
    if (lead >= 0) begin
      e_val = 1'b1; e_ln = m_ln[lead]; e_st = m_st[lead];
      for (int i = 0; i < NS; i++)
        if (m_pend[i] && m_ln[i] == e_ln && m_st[i] == e_st) begin
          e_gnt[i] = 1'b1; e_mk |= m_mk[i];
        end
    end
  endfunction

  task automatic cycle();
    predict();
    for (int i = 0; i < NS; i++) begin
      in_valid[i] = d_v[i]; in_store[i] = d_st[i];
      in_line[i*LW +: LW] = d_ln[i]; in_mask[i*MW +: MW] = d_mk[i];
    end
    for (int i = 0; i < NS; i++) begin
      if (!m_pend[i] && d_v[i]) begin
        m_st[i] = d_st[i]; m_ln[i] = d_ln[i]; m_mk[i] = d_mk[i];
      end
    end
    m_pend = (m_pend & ~e_gnt) | (d_v & ~m_pend);
    @(posedge clk); @(negedge clk);
    chk(grant == e_gnt, "R5 R6 grant", 64'(grant), 64'(e_gnt));
    chk(mrg_mask == e_mk, "R5 mask", 64'(mrg_mask), 64'(e_mk));
    chk(mrg_valid == e_val, "R9 valid", 64'(mrg_valid), 64'(e_val));
    chk(mrg_line == e_ln && mrg_store == e_st, "R4 line/op",
        {35'd0, mrg_store, mrg_line}, {35'd0, e_st, e_ln});
    chk(slot_pending == m_pend, "R2 R7 pending", 64'(slot_pending), 64'(m_pend));
    if (!e_val)
      chk(grant == '0 && mrg_mask == '0 && mrg_line == '0, "R8 idle",
          64'(mrg_mask), 64'd0);
  endtask

  task automatic clear_drive();
    d_v = '0; d_st = '0;
    for (int i = 0; i < NS; i++) begin d_ln[i] = '0; d_mk[i] = '0; end
  endtask

  initial begin
    #(CLK_P*150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    in_valid = '0; in_store = '0; in_line = '0; in_mask = '0;
    m_pend = '0; m_st = '0;
    for (int i = 0; i < NS; i++) begin m_ln[i] = '0; m_mk[i] = '0; end
    clear_drive();
    repeat (3) @(negedge clk);
    chk(slot_pending == '0 && grant == '0 && !mrg_valid && mrg_mask == '0,
        "R1 reset", 64'(slot_pending), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(slot_pending == '0 && !mrg_valid && mrg_line == '0, "R1 after release",
        64'(slot_pending), 64'd0);

    // Directed: all sixteen slots load the same line (R5)
    clear_drive();
    for (int i = 0; i < NS; i++) begin
      d_v[i] = 1'b1; d_ln[i] = 28'h0ABCDE0; d_mk[i] = MW'(1) << i;
    end
    cycle(); clear_drive(); cycle();
    chk(mrg_mask == 16'hFFFF && grant == '1, "R5 full merge", 64'(mrg_mask), 64'hFFFF);
    cycle();

    // Directed: same line, mixed ops split into two accesses (R6)
    for (int i = 0; i < 4; i++) begin
      d_v[i] = 1'b1; d_ln[i] = 28'h10; d_st[i] = i[0]; d_mk[i] = MW'(3) << (2*i);
    end
    cycle(); clear_drive(); cycle();
    chk(grant == 16'h0005 && !mrg_store && mrg_mask == 16'h0033, "R6 loads first",
        64'(grant), 64'h5);
    cycle();
    chk(grant == 16'h000A && mrg_store && mrg_mask == 16'h00CC, "R6 stores next",
        64'(grant), 64'hA);
    cycle();

    // Directed: write to a blocked pending slot is ignored (R3)
    d_v[0] = 1'b1; d_ln[0] = 28'h1; d_mk[0] = 16'h000F;
    d_v[3] = 1'b1; d_ln[3] = 28'h2; d_mk[3] = 16'h00F0;
    cycle(); clear_drive();
    d_v[3] = 1'b1; d_ln[3] = 28'h1; d_mk[3] = 16'hFF00;
    cycle(); clear_drive();
    chk(grant == 16'h0001, "R3 slot0 alone", 64'(grant), 64'h1);
    cycle();
    chk(grant == 16'h0008 && mrg_line == 28'h2 && mrg_mask == 16'h00F0,
        "R3 held request", 64'(mrg_mask), 64'h00F0);
    cycle();

    // Random phase
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < NS; i++) begin
        d_v[i]  = ($urandom % 100) < 55;
        d_st[i] = $urandom % 2;
        d_ln[i] = LW'(28'h0400000 + ($urandom % 4));
        d_mk[i] = MW'($urandom);
      end
      if (n % 200 == 199) clear_drive();
      cycle();
    end
    clear_drive();
    repeat (NS + 2) cycle();
    chk(slot_pending == '0 && !mrg_valid, "R8 drained", 64'(slot_pending), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule